// File: doc/BRIEF.md
# Two-Slot Core Clock Source Switcher

This block drives the configuration of a core clock generator that has two source slots and a single select bit that chooses which slot is live. A request gives a 3-bit source select, a 4-bit source divider and a 2-bit bus-clock divider. The block always loads the new setting into the slot that is not live, then flips the select bit so that the new slot goes live. The live clock never sees a half-written setting.

The bus-clock divider sits in the select register next to the select bit. The block updates it before the flip when it is rising and after the flip when it is falling. This order keeps the bus clock from running too fast during the change. Before any of these writes, the block stores a fixed wait-state count in the control register. Each register update takes one clock cycle, so the write order can be seen directly on the two register images the block drives. A req/busy/done handshake starts a change and reports its end.

Top module: `core_clk_switcher`

## Requirements
- R1: When reset is active, both register images are zero, `busy_o` is low and `done_o` is low. With the select bit at 0, the upper slot is live and the bus divider is 0.
- R2: The control image has two slots. The lower slot holds the source select at bits 6:4 and the divider at bits 3:0. The upper slot holds the source select at bits 14:12 and the divider at bits 11:8. If select bit 0 is 0, the block writes the lower slot and then sets the bit to 1. If the bit is 1, the block writes the upper slot and then clears the bit to 0.
- R3: Within the target slot, the block writes the source select first and the divider in the next cycle. The select bit flips one cycle after the divider write.
- R4: The first write after an accepted request sets control bits 23:16 to the wait-state count 100. All other bits of both images are left unchanged.
- R5: If the requested bus divider is larger than select-image bits 2:1, the block writes it there in the cycle after the wait-state write, before the slot writes.
- R6: If the requested bus divider is smaller than the current one, the block writes it in the cycle after the flip. This is the last write of the sequence.
- R7: If the requested bus divider equals the current one, the block does not write it, and the flip is the last write.
- R8: `busy_o` is high from the cycle after the request is accepted through the cycle that ends with the last write. `done_o` is high for exactly one cycle after that, while `busy_o` is low.
- R9: A request raised while `busy_o` is high is ignored. It changes neither image nor the write sequence in progress.
- R10: The fields of the live slot are never modified by a change.
- R11: At most one of the two register images changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request a clock change; accepted when not busy |
| src_sel_i | input | 3 | Requested source select |
| src_div_i | input | 4 | Requested source divider |
| bus_div_i | input | 2 | Requested bus-clock divider |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | One-cycle pulse after the last write |
| ctrl_img_o | output | 32 | Control register image (slots and wait-state field) |
| sel_img_o | output | 32 | Select register image (select bit 0, bus divider 2:1) |

## Verification
The bench drives a rising bus divider, a falling one and an unchanged one, from each value of the select bit. These cases catch a design that writes the bus field on the wrong side of the flip, or that adds a needless write when the divider is unchanged. Back-to-back changes prove that the slot alternates; a design that wrote the live slot would corrupt the fields of the running clock. Requests raised mid-sequence and in the done cycle show whether a busy design restarts or drops a request it should accept. Every edge is also checked so that no two registers change at once, which a design that merged the divider write with the flip would violate.

// File: rtl/clk_switch_pkg.sv
package clk_switch_pkg;

  localparam int SRC_W      = 3;
  localparam int DIV_W      = 4;
  localparam int BUS_W      = 2;
  localparam int WAIT_W     = 8;
  localparam int WAIT_LSB   = 16;
  localparam int LO_SEL_LSB = 4;
  localparam int LO_DIV_LSB = 0;
  localparam int HI_SEL_LSB = 12;
  localparam int HI_DIV_LSB = 8;
  localparam int BUS_LSB    = 1;
  localparam int LIVE_BIT   = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BUS_PRE,
    ST_SRC,
    ST_DIV,
    ST_FLIP,
    ST_BUS_POST
  } step_e;

endpackage

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
  import clk_switch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [BUS_W-1:0] bus_new_i,
  input  logic [BUS_W-1:0] bus_cur_i,
  output step_e            step_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);

  step_e step_q, step_d;
  logic  up_q, dn_q;
  logic  done_q, done_d;

  assign accept_o = req_i && (step_q == ST_IDLE);

  always_comb begin
    step_d = step_q;
    done_d = 1'b0;
    unique case (step_q)
      ST_IDLE:     if (accept_o) step_d = ST_WAIT;
      ST_WAIT:     step_d = up_q ? ST_BUS_PRE : ST_SRC;
      ST_BUS_PRE:  step_d = ST_SRC;
      ST_SRC:      step_d = ST_DIV;
      ST_DIV:      step_d = ST_FLIP;
      ST_FLIP: begin
        step_d = dn_q ? ST_BUS_POST : ST_IDLE;
        done_d = !dn_q;
      end
      ST_BUS_POST: begin
        step_d = ST_IDLE;
        done_d = 1'b1;
      end
      default:     step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (accept_o) begin
      up_q <= bus_new_i > bus_cur_i;
      dn_q <= bus_new_i < bus_cur_i;
    end
  end

  assign step_o = step_q;
  assign busy_o = (step_q != ST_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/clk_switch_regs.sv
module clk_switch_regs
  import clk_switch_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int WAIT_VAL = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  step_e            step_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic [DIV_W-1:0] src_div_i,
  input  logic [BUS_W-1:0] bus_div_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] sel_o,
  output logic [BUS_W-1:0] bus_cur_o
);

  localparam int NSLOT = 2;

  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [REG_W-1:0] sel_q, sel_d;
  logic             ctrl_we, sel_we;
  logic [SRC_W-1:0] req_sel_q;
  logic [DIV_W-1:0] req_div_q;
  logic [BUS_W-1:0] req_bus_q;

  // Field offsets of each slot; slot 0 is written while the select bit is 0.
  int unsigned slot_sel_lsb [NSLOT];
  int unsigned slot_div_lsb [NSLOT];
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_sel_lsb[s] = (s == 0) ? LO_SEL_LSB : HI_SEL_LSB;
    assign slot_div_lsb[s] = (s == 0) ? LO_DIV_LSB : HI_DIV_LSB;
  end

  int unsigned tgt_sel_lsb, tgt_div_lsb;
  assign tgt_sel_lsb = slot_sel_lsb[sel_q[LIVE_BIT]];
  assign tgt_div_lsb = slot_div_lsb[sel_q[LIVE_BIT]];

  assign ctrl_we = (step_i == ST_WAIT) || (step_i == ST_SRC) || (step_i == ST_DIV);
  assign sel_we  = (step_i == ST_BUS_PRE) || (step_i == ST_FLIP) ||
                   (step_i == ST_BUS_POST);

  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    unique case (step_i)
      ST_WAIT:     ctrl_d[WAIT_LSB +: WAIT_W] = WAIT_W'(WAIT_VAL);
      ST_SRC:      ctrl_d[tgt_sel_lsb +: SRC_W] = req_sel_q;
      ST_DIV:      ctrl_d[tgt_div_lsb +: DIV_W] = req_div_q;
      ST_BUS_PRE,
      ST_BUS_POST: sel_d[BUS_LSB +: BUS_W] = req_bus_q;
      ST_FLIP:     sel_d[LIVE_BIT] = !sel_q[LIVE_BIT];
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sel_q <= '0;
      req_div_q <= '0;
      req_bus_q <= '0;
    end else if (accept_i) begin
      req_sel_q <= src_sel_i;
      req_div_q <= src_div_i;
      req_bus_q <= bus_div_i;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign sel_o     = sel_q;
  assign bus_cur_o = sel_q[BUS_LSB +: BUS_W];

endmodule

// File: rtl/core_clk_switcher.sv
module core_clk_switcher
  import clk_switch_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int WAIT_VAL = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [2:0]       src_sel_i,
  input  logic [3:0]       src_div_i,
  input  logic [1:0]       bus_div_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [REG_W-1:0] ctrl_img_o,
  output logic [REG_W-1:0] sel_img_o
);

  step_e            step;
  logic             accept;
  logic [BUS_W-1:0] bus_cur;

  clk_switch_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .bus_new_i (bus_div_i),
    .bus_cur_i (bus_cur),
    .step_o    (step),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  clk_switch_regs #(
    .REG_W    (REG_W),
    .WAIT_VAL (WAIT_VAL)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .step_i    (step),
    .src_sel_i (src_sel_i),
    .src_div_i (src_div_i),
    .bus_div_i (bus_div_i),
    .ctrl_o    (ctrl_img_o),
    .sel_o     (sel_img_o),
    .bus_cur_o (bus_cur)
  );

endmodule

// File: rtl/core_clk_switcher_chk.sv
module core_clk_switcher_chk #(
  parameter int REG_W    = 32,
  parameter int WAIT_VAL = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic [REG_W-1:0] ctrl_img_o,
  input logic [REG_W-1:0] sel_img_o
);

  // R8: done is never high together with busy
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8: done lasts one cycle
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: done follows a busy period
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));

  // R9: no register write while idle, whatever the request input does
  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> ($stable(ctrl_img_o) && $stable(sel_img_o)));

  // R11: one register per edge
  a_r11_single_reg: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(ctrl_img_o) || $stable(sel_img_o)));

  // R3: the select flip and the bus field never move on the same edge
  a_r3_flip_alone: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(sel_img_o[0]) || $stable(sel_img_o[2:1])));

  // R4: the wait-state count is the first write
  a_r4_wait_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> (ctrl_img_o[23:16] == 8'(WAIT_VAL)));

endmodule

bind core_clk_switcher core_clk_switcher_chk #(
  .REG_W    (REG_W),
  .WAIT_VAL (WAIT_VAL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ctrl_img_o (ctrl_img_o),
  .sel_img_o  (sel_img_o)
);

// File: tb/test_core_clk_switcher.sv
module test_core_clk_switcher;

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [2:0]  src_sel_i;
  logic [3:0]  src_div_i;
  logic [1:0]  bus_div_i;
  logic        busy_o;
  logic        done_o;
  logic [31:0] ctrl_img_o;
  logic [31:0] sel_img_o;

  int n_cmp;
  int n_bad;
  int cyc;

  core_clk_switcher i_core_clk_switcher (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .src_sel_i  (src_sel_i),
    .src_div_i  (src_div_i),
    .bus_div_i  (bus_div_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ctrl_img_o (ctrl_img_o),
    .sel_img_o  (sel_img_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model: a queue of register images, one entry per pending write.
  logic [31:0] m_ctrl, m_sel;
  logic        m_done;
  logic [31:0] q_ctrl[$];
  logic [31:0] q_sel[$];
  string       q_tag[$];
  string       m_tag;
  bit          m_r9;

  task automatic plan_change(input logic [2:0] s, input logic [3:0] d, input logic [1:0] b);
    logic [31:0] c;
    logic [31:0] k;
    int          cur_bus;
    int          sl;
    int          dl;
    c = m_ctrl;
    k = m_sel;
    cur_bus = int'(k[2:1]);
    c[23:16] = 8'd100;
    q_ctrl.push_back(c); q_sel.push_back(k); q_tag.push_back("R4");
    if (int'(b) > cur_bus) begin
      k[2:1] = b;
      q_ctrl.push_back(c); q_sel.push_back(k); q_tag.push_back("R5");
    end
    sl = (k[0] == 1'b0) ? 4 : 12;
    dl = (k[0] == 1'b0) ? 0 : 8;
    for (int i = 0; i < 3; i++) c[sl + i] = s[i];
    q_ctrl.push_back(c); q_sel.push_back(k); q_tag.push_back("R2 R3 R10");
    for (int i = 0; i < 4; i++) c[dl + i] = d[i];
    q_ctrl.push_back(c); q_sel.push_back(k); q_tag.push_back("R3 R10");
    k[0] = ~k[0];
    q_ctrl.push_back(c); q_sel.push_back(k);
    q_tag.push_back((int'(b) == cur_bus) ? "R2 R7" : "R2");
    if (int'(b) < cur_bus) begin
      k[2:1] = b;
      q_ctrl.push_back(c); q_sel.push_back(k); q_tag.push_back("R6");
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0;
      m_sel  = '0;
      m_done = 1'b0;
      m_tag  = "R1";
      m_r9   = 1'b0;
      q_ctrl.delete(); q_sel.delete(); q_tag.delete();
    end else if (q_ctrl.size() != 0) begin
      if (req_i) m_r9 = 1'b1;
      m_ctrl = q_ctrl.pop_front();
      m_sel  = q_sel.pop_front();
      m_tag  = q_tag.pop_front();
      if (m_r9) m_tag = {m_tag, " R9"};
      m_done = (q_ctrl.size() == 0);
    end else begin
      m_done = 1'b0;
      m_r9   = 1'b0;
      m_tag  = "R9";
      if (req_i) plan_change(src_sel_i, src_div_i, bus_div_i);
    end
  end

  // Comparison on every clock, away from the active edge.
  logic [31:0] p_ctrl, p_sel;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      n_cmp++;
      if (busy_o !== (q_ctrl.size() != 0)) begin
        n_bad++;
        $display("FAIL R8 busy: actual %0b expected %0b (cycle %0d)", busy_o, q_ctrl.size() != 0, cyc);
      end
      n_cmp++;
      if (done_o !== m_done) begin
        n_bad++;
        $display("FAIL R8 done: actual %0b expected %0b (cycle %0d)", done_o, m_done, cyc);
      end
      n_cmp++;
      if (ctrl_img_o !== m_ctrl) begin
        n_bad++;
        $display("FAIL %s ctrl: actual %h expected %h (cycle %0d)", m_tag, ctrl_img_o, m_ctrl, cyc);
      end
      n_cmp++;
      if (sel_img_o !== m_sel) begin
        n_bad++;
        $display("FAIL %s sel: actual %h expected %h (cycle %0d)", m_tag, sel_img_o, m_sel, cyc);
      end
      n_cmp++;
      if ((ctrl_img_o !== p_ctrl) && (sel_img_o !== p_sel)) begin
        n_bad++;
        $display("FAIL R11 both images changed: actual ctrl %h sel %h expected one of them held", ctrl_img_o, sel_img_o);
      end
    end
    p_ctrl = ctrl_img_o;
    p_sel  = sel_img_o;
  end

  task automatic request(input logic [2:0] s, input logic [3:0] d, input logic [1:0] b);
    @(negedge clk);
    req_i = 1'b1; src_sel_i = s; src_div_i = d; bus_div_i = b;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0;
    p_ctrl = '0; p_sel = '0;
    rst_n = 1'b0; req_i = 1'b0;
    src_sel_i = '0; src_div_i = '0; bus_div_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (ctrl_img_o !== '0 || sel_img_o !== '0 || busy_o !== 1'b0 || done_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %h %h %0b %0b expected 0 0 0 0", ctrl_img_o, sel_img_o, busy_o, done_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    request(3'd5, 4'd3, 2'd2); wait_done();   // R5 rising bus, lower slot
    request(3'd2, 4'd9, 2'd1); wait_done();   // R6 falling bus, upper slot
    request(3'd7, 4'd1, 2'd1); wait_done();   // R7 equal bus
    request(3'd4, 4'd15, 2'd3); wait_done();  // R5 rising to max, upper slot
    request(3'd1, 4'd0, 2'd0); wait_done();   // R6 falling to zero

    // R9: requests held high while busy are ignored
    @(negedge clk);
    req_i = 1'b1; src_sel_i = 3'd6; src_div_i = 4'd7; bus_div_i = 2'd2;
    @(negedge clk);
    src_sel_i = 3'd3; src_div_i = 4'd12; bus_div_i = 2'd0;
    repeat (3) @(negedge clk);
    req_i = 1'b0;
    wait_done();

    // R8: a request in the done cycle is accepted at once
    req_i = 1'b1; src_sel_i = 3'd2; src_div_i = 4'd4; bus_div_i = 2'd1;
    @(negedge clk);
    req_i = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);

    for (int n = 0; n < 40; n++) begin
      request(3'(n * 3 + 1), 4'(n * 7 + 2), 2'(n * 5 + n / 4));
      wait_done();
    end
    repeat (5) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule